// File: doc/BRIEF.md
# Delay-Slot Fetch Sequencer with Selectable Slot Annulment

This block produces the fetch address for an in-order front end in which every branch is followed by exactly one delay-slot instruction. It keeps a current fetch address and a successor address. Each cycle it takes the resolution of the instruction now at the fetch address: whether it is a branch, whether it is conditional, whether it was taken, its displacement or absolute target, and a nullify bit. From these it forms the successor address. A taken branch therefore produces the order branch, slot, target.

Alongside each fetch address the block drives an execute qualifier. The qualifier is low for a delay-slot instruction that is squashed. A squashed slot still uses one fetch cycle, but it must change no architectural state. The squash rule is chosen at run time from five policies. One of them picks squash-on-taken or squash-on-untaken from the branch direction, which suits forward if-then branches and backward loop closers.

A stall holds the whole sequencer still. A trap sends fetch to a fixed vector and keeps the fetch address, the successor address and the pending squash flag in shadow registers. A later restart reloads them, so a slot that was squashed before the trap is still squashed when it is fetched again.

Top module: `delay_slot_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `fetch_pc` is 0, `next_pc` is `INSN_BYTES` and `fetch_exec` is 1.
- R2: In a cycle with no trap, no restart and no stall, the next `fetch_pc` equals the present `next_pc`. With no taken branch, `next_pc` steps by `INSN_BYTES`.
- R3: A taken branch that is accepted at address P with successor S gives `fetch_pc` = S and `next_pc` = target in the following cycle, and `fetch_pc` = target one cycle after that. The target is `br_target` when `br_absolute`=1, and otherwise P plus the sign-extended `br_offset`.
- R4: With `br_nullify`=0 the slot always executes. Policy code 0 (never) never squashes, and policy code 1 (always) squashes whenever `br_nullify`=1.
- R5: With `br_nullify`=1, policy code 2 squashes the slot when the branch is effectively taken, and policy code 3 squashes it when the branch is not taken. An unconditional branch counts as taken.
- R6: Under policy code 4 (by direction) with `br_nullify`=1, a conditional forward branch squashes when taken, and a conditional backward branch squashes when not taken. Backward means a negative `br_offset`; for an absolute branch it means `br_target` < P.
- R7: Under policy code 4 an unconditional branch with `br_nullify`=1 squashes its slot in either direction.
- R8: A squashed slot occupies exactly one fetch cycle with `fetch_exec`=0. Any branch resolution presented during that cycle is ignored.
- R9: While `stall`=1 (and no trap or restart), `fetch_pc`, `next_pc` and `fetch_exec` hold. Branch inputs are ignored.
- R10: `trap`=1 gives `fetch_pc` = `TRAP_VEC`, `next_pc` = `TRAP_VEC`+`INSN_BYTES` and `fetch_exec`=1 in the next cycle. A trap takes priority over restart and stall.
- R11: `restart`=1 restores the fetch address, the successor address and the squash flag that were saved by the last trap. A squashed slot that was interrupted comes back squashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold all sequencer state |
| trap | input | 1 | Redirect to trap vector and save state |
| restart | input | 1 | Reload state saved by last trap |
| br_valid | input | 1 | Instruction at `fetch_pc` is a resolved branch |
| br_cond | input | 1 | Branch is conditional |
| br_taken | input | 1 | Condition outcome (conditional only) |
| br_absolute | input | 1 | Use `br_target` instead of displacement |
| br_nullify | input | 1 | Enable slot annulment for this branch |
| br_offset | input | OW | Signed displacement, two's complement |
| br_target | input | AW | Absolute target address |
| policy | input | 3 | Annulment policy code 0..4 |
| fetch_pc | output | AW | Current fetch address |
| next_pc | output | AW | Successor fetch address |
| fetch_exec | output | 1 | Instruction at `fetch_pc` commits |

## Verification
The bench builds the block with a 12-bit address and a 6-bit displacement, and puts the trap vector at 0x800. These narrow widths keep forward and backward displacement targets and absolute targets on either side of the branch close together. This allows a full sweep of all five policies against every combination of conditional, taken, nullify, direction and addressing mode. Directed sequences then place a stall, a bogus branch, and a trap followed by restart on a squashed slot.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef enum logic [2:0] {
        POL_NEVER      = 3'd0,
        POL_ALWAYS     = 3'd1,
        POL_ON_TAKEN   = 3'd2,
        POL_ON_UNTAKEN = 3'd3,
        POL_BY_DIR     = 3'd4
    } squash_pol_e;

    typedef struct packed {
        logic valid;
        logic cond;
        logic taken;
        logic absolute;
        logic nullify;
    } br_flags_t;

    // Effective direction of flow: unconditional transfers always redirect.
    function automatic logic flow_taken(br_flags_t f);
        return !f.cond || f.taken;
    endfunction

    // Slot squash decision for one resolved branch.
    function automatic logic squash_decide(squash_pol_e pol, br_flags_t f, logic backward);
        logic res;
        res = 1'b0;
        if (f.nullify) begin
            case (pol)
                POL_NEVER:      res = 1'b0;
                POL_ALWAYS:     res = 1'b1;
                POL_ON_TAKEN:   res = flow_taken(f);
                POL_ON_UNTAKEN: res = !flow_taken(f);
                POL_BY_DIR:     res = !f.cond ? 1'b1 : (backward ? !f.taken : f.taken);
                default:        res = 1'b0;
            endcase
        end
        return res;
    endfunction

endpackage

// File: rtl/dss_target.sv
module dss_target #(
    parameter int AW = 32,
    parameter int OW = 16
) (
    input  logic [AW-1:0] pc,
    input  logic [OW-1:0] offset,
    input  logic [AW-1:0] abs_target,
    input  logic          absolute,
    output logic [AW-1:0] target,
    output logic          backward
);
    logic [AW-1:0] ext;

    generate
        if (AW > OW) begin : g_sext
            assign ext = {{(AW-OW){offset[OW-1]}}, offset};
        end else begin : g_trunc
            assign ext = offset[AW-1:0];
        end
    endgenerate

    always_comb begin
        if (absolute) begin
            target   = abs_target;
            backward = (abs_target < pc);
        end else begin
            target   = pc + ext;
            backward = offset[OW-1];
        end
    end
endmodule

// File: rtl/dss_annul.sv
module dss_annul
    import dss_pkg::*;
(
    input  br_flags_t   flags,
    input  logic [2:0]  policy,
    input  logic        backward,
    output logic        squash,
    output logic        redirect
);
    always_comb begin
        squash   = squash_decide(squash_pol_e'(policy), flags, backward);
        redirect = flow_taken(flags);
    end
endmodule

// File: rtl/dss_shadow.sv
module dss_shadow #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] npc_in,
    input  logic          annul_in,
    output logic [AW-1:0] pc_sv,
    output logic [AW-1:0] npc_sv,
    output logic          annul_sv
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_sv    <= '0;
            npc_sv   <= '0;
            annul_sv <= 1'b0;
        end else if (capture) begin
            pc_sv    <= pc_in;
            npc_sv   <= npc_in;
            annul_sv <= annul_in;
        end
    end
endmodule

// File: rtl/delay_slot_seq.sv
module delay_slot_seq
    import dss_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          OW         = 16,
    parameter int          INSN_BYTES = 4,
    parameter logic [31:0] RESET_PC   = 32'h0,
    parameter logic [31:0] TRAP_VEC   = 32'h100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stall,
    input  logic          trap,
    input  logic          restart,
    input  logic          br_valid,
    input  logic          br_cond,
    input  logic          br_taken,
    input  logic          br_absolute,
    input  logic          br_nullify,
    input  logic [OW-1:0] br_offset,
    input  logic [AW-1:0] br_target,
    input  logic [2:0]    policy,
    output logic [AW-1:0] fetch_pc,
    output logic [AW-1:0] next_pc,
    output logic          fetch_exec
);
    localparam logic [AW-1:0] STEP  = AW'(INSN_BYTES);
    localparam logic [AW-1:0] RST_A = AW'(RESET_PC);
    localparam logic [AW-1:0] VEC_A = AW'(TRAP_VEC);

    logic [AW-1:0] pc_q, npc_q;
    logic          annul_q;
    logic [AW-1:0] tgt;
    logic          backward, squash, redirect, accept;
    logic [AW-1:0] pc_sv, npc_sv;
    logic          annul_sv;
    br_flags_t     flags;

    always_comb begin
        flags.valid    = br_valid;
        flags.cond     = br_cond;
        flags.taken    = br_taken;
        flags.absolute = br_absolute;
        flags.nullify  = br_nullify;
    end

    // A squashed slot cannot itself transfer control.
    assign accept = flags.valid && !annul_q;

    dss_target #(.AW(AW), .OW(OW)) u_target (
        .pc         (pc_q),
        .offset     (br_offset),
        .abs_target (br_target),
        .absolute   (br_absolute),
        .target     (tgt),
        .backward   (backward)
    );

    dss_annul u_annul (
        .flags    (flags),
        .policy   (policy),
        .backward (backward),
        .squash   (squash),
        .redirect (redirect)
    );

    dss_shadow #(.AW(AW)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .capture  (trap),
        .pc_in    (pc_q),
        .npc_in   (npc_q),
        .annul_in (annul_q),
        .pc_sv    (pc_sv),
        .npc_sv   (npc_sv),
        .annul_sv (annul_sv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= RST_A;
            npc_q   <= RST_A + STEP;
            annul_q <= 1'b0;
        end else if (trap) begin
            pc_q    <= VEC_A;
            npc_q   <= VEC_A + STEP;
            annul_q <= 1'b0;
        end else if (restart) begin
            pc_q    <= pc_sv;
            npc_q   <= npc_sv;
            annul_q <= annul_sv;
        end else if (!stall) begin
            pc_q    <= npc_q;
            npc_q   <= (accept && redirect) ? tgt : npc_q + STEP;
            annul_q <= accept && squash;
        end
    end

    assign fetch_pc   = pc_q;
    assign next_pc    = npc_q;
    assign fetch_exec = !annul_q;
endmodule

// File: rtl/delay_slot_seq_chk.sv
module delay_slot_seq_chk
    import dss_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          INSN_BYTES = 4,
    parameter logic [31:0] TRAP_VEC   = 32'h100
) (
    input logic          clk,
    input logic          rst,
    input logic          stall,
    input logic          trap,
    input logic          restart,
    input logic          br_valid,
    input logic          br_cond,
    input logic          br_nullify,
    input logic [2:0]    policy,
    input logic [AW-1:0] fetch_pc,
    input logic [AW-1:0] next_pc,
    input logic          fetch_exec
);
    logic advance;
    assign advance = !stall && !trap && !restart;

    p_adv_r2: assert property (@(posedge clk) disable iff (rst)
        advance |=> fetch_pc == $past(next_pc));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (stall && !trap && !restart) |=> ($stable(fetch_pc) && $stable(next_pc) && $stable(fetch_exec)));

    p_trap_vec_r10: assert property (@(posedge clk) disable iff (rst)
        trap |=> (fetch_pc == AW'(TRAP_VEC) && next_pc == AW'(TRAP_VEC) + AW'(INSN_BYTES) && fetch_exec));

    p_never_pol_r4: assert property (@(posedge clk) disable iff (rst)
        (advance && br_valid && policy == 3'(POL_NEVER)) |=> fetch_exec);

    p_uncond_dir_r7: assert property (@(posedge clk) disable iff (rst)
        (advance && br_valid && fetch_exec && !br_cond && br_nullify && policy == 3'(POL_BY_DIR)) |=> !fetch_exec);

    p_no_nullify_r4: assert property (@(posedge clk) disable iff (rst)
        (advance && br_valid && !br_nullify) |=> fetch_exec);

    p_single_slot_r8: assert property (@(posedge clk) disable iff (rst)
        (advance && !fetch_exec) |=> fetch_exec);
endmodule

bind delay_slot_seq delay_slot_seq_chk #(
    .AW(AW), .INSN_BYTES(INSN_BYTES), .TRAP_VEC(TRAP_VEC)
) u_chk (
    .clk(clk), .rst(rst), .stall(stall), .trap(trap), .restart(restart),
    .br_valid(br_valid), .br_cond(br_cond), .br_nullify(br_nullify),
    .policy(policy), .fetch_pc(fetch_pc), .next_pc(next_pc), .fetch_exec(fetch_exec)
);

// File: tb/delay_slot_seq_test.sv
module delay_slot_seq_test;
    localparam int AW = 12;
    localparam int OW = 6;

    logic          clk = 1'b0;
    logic          rst, stall, trap, restart;
    logic          br_valid, br_cond, br_taken, br_absolute, br_nullify;
    logic [OW-1:0] br_offset;
    logic [AW-1:0] br_target;
    logic [2:0]    policy;
    logic [AW-1:0] fetch_pc, next_pc;
    logic          fetch_exec;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    delay_slot_seq #(.AW(AW), .OW(OW), .INSN_BYTES(4), .RESET_PC(32'h0), .TRAP_VEC(32'h800)) uut (
        .clk(clk), .rst(rst), .stall(stall), .trap(trap), .restart(restart),
        .br_valid(br_valid), .br_cond(br_cond), .br_taken(br_taken),
        .br_absolute(br_absolute), .br_nullify(br_nullify),
        .br_offset(br_offset), .br_target(br_target), .policy(policy),
        .fetch_pc(fetch_pc), .next_pc(next_pc), .fetch_exec(fetch_exec)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs;
        stall = 0; trap = 0; restart = 0;
        br_valid = 0; br_cond = 0; br_taken = 0; br_absolute = 0; br_nullify = 0;
        br_offset = '0; br_target = '0;
    endtask

    task automatic do_reset;
        idle_inputs();
        rst = 1;
        tick(); tick();
        rst = 0;
    endtask

    // Independent model of the squash rule from the requirements.
    function automatic bit model_squash(int pol, bit cnd, bit tk, bit nul, bit back);
        bit goes;
        goes = cnd ? tk : 1'b1;
        if (!nul) return 0;
        if (pol == 1) return 1;
        if (pol == 2) return goes;
        if (pol == 3) return !goes;
        if (pol == 4) begin
            if (!cnd) return 1;
            if (back) return !tk;
            return tk;
        end
        return 0;
    endfunction

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        policy = 0;
        rst = 1;
        idle_inputs();
        @(negedge clk);
        // R1: reset state while asserted
        chk_eq("R1 pc in reset", int'(fetch_pc), 0);
        chk_eq("R1 npc in reset", int'(next_pc), 4);
        chk_eq("R1 exec in reset", int'(fetch_exec), 1);
        do_reset();
        chk_eq("R1 pc after reset", int'(fetch_pc), 0);
        chk_eq("R1 exec after reset", int'(fetch_exec), 1);
        tick();
        chk_eq("R2 sequential step", int'(fetch_pc), 4);
        chk_eq("R2 npc step", int'(next_pc), 8);

        // Sweep: R3 R4 R5 R6 R7
        for (int pol = 0; pol < 5; pol++)
        for (int cnd = 0; cnd < 2; cnd++)
        for (int tk = 0; tk < 2; tk++)
        for (int nul = 0; nul < 2; nul++)
        for (int back = 0; back < 2; back++)
        for (int ab = 0; ab < 2; ab++) begin
            int tgt;
            bit goes;
            bit sq;
            string tag;
            do_reset();
            policy = 3'(pol);
            repeat (4) tick();
            chk_eq("R2 pc reaches 16", int'(fetch_pc), 16);
            if (ab != 0) tgt = (back != 0) ? 4 : 'h400;
            else         tgt = (back != 0) ? 8 : 24;
            goes = (cnd == 0) || (tk != 0);
            sq   = model_squash(pol, cnd[0], tk[0], nul[0], back[0]);
            tag  = (pol == 4) ? ((cnd == 0) ? "R7" : "R6")
                 : ((pol >= 2) ? "R5" : "R4");
            br_valid = 1; br_cond = cnd[0]; br_taken = tk[0];
            br_nullify = nul[0]; br_absolute = ab[0];
            br_offset = (back != 0) ? 6'(-8) : 6'd8;
            br_target = 12'(ab != 0 ? tgt : 'h7f0);
            tick();
            idle_inputs();
            chk_eq("R3 slot address", int'(fetch_pc), 20);
            chk_eq("R3 successor after branch", int'(next_pc), goes ? tgt : 24);
            chk_eq({tag, " slot exec"}, int'(fetch_exec), sq ? 0 : 1);
            tick();
            chk_eq("R3 post-slot address", int'(fetch_pc), goes ? tgt : 24);
            chk_eq("R8 one squashed cycle", int'(fetch_exec), 1);
        end

        // R8: branch offered during a squashed slot is ignored
        do_reset();
        policy = 3'd1;
        repeat (4) tick();
        br_valid = 1; br_cond = 0; br_nullify = 1; br_offset = 6'd8;
        tick();
        br_offset = 6'd28;
        tick();
        idle_inputs();
        chk_eq("R8 ignored branch in squashed slot", int'(fetch_pc), 24);
        chk_eq("R8 npc unaffected", int'(next_pc), 28);

        // R9: stall during a squashed slot, with a branch offered
        do_reset();
        policy = 3'd1;
        repeat (4) tick();
        br_valid = 1; br_cond = 0; br_nullify = 1; br_offset = 6'd8;
        tick();
        stall = 1; br_valid = 1; br_cond = 0; br_nullify = 0; br_offset = 6'd28;
        annul_hold_blk: for (int k = 0; k < 2; k++) begin
            tick();
            chk_eq("R9 stall holds pc", int'(fetch_pc), 20);
            chk_eq("R9 stall holds npc", int'(next_pc), 24);
            chk_eq("R9 stall holds exec", int'(fetch_exec), 0);
        end
        idle_inputs();
        tick();
        chk_eq("R9 resume after stall", int'(fetch_pc), 24);
        chk_eq("R9 exec after stall", int'(fetch_exec), 1);

        // R10 / R11: trap on a squashed slot and restart
        do_reset();
        policy = 3'd4;
        repeat (4) tick();
        br_valid = 1; br_cond = 1; br_taken = 0; br_nullify = 1; br_offset = 6'(-8);
        tick();
        idle_inputs();
        chk_eq("R6 backward untaken squashed", int'(fetch_exec), 0);
        trap = 1; stall = 1; restart = 1;
        tick();
        idle_inputs();
        chk_eq("R10 trap vector", int'(fetch_pc), 'h800);
        chk_eq("R10 trap npc", int'(next_pc), 'h804);
        chk_eq("R10 trap exec", int'(fetch_exec), 1);
        tick();
        chk_eq("R10 handler runs", int'(fetch_pc), 'h804);
        restart = 1;
        tick();
        idle_inputs();
        chk_eq("R11 restart pc", int'(fetch_pc), 20);
        chk_eq("R11 restart npc", int'(next_pc), 24);
        chk_eq("R11 slot stays squashed", int'(fetch_exec), 0);
        tick();
        chk_eq("R11 continue after slot", int'(fetch_pc), 24);
        chk_eq("R11 exec after slot", int'(fetch_exec), 1);

        finish_run();
    end
endmodule